// File: doc/BRIEF.md
# PWM Duty Cycle Meter

This block measures the duty cycle of a single pulse-width-modulated input. The input is synchronized, and each rising and falling edge is stamped against a free-running timer. The timer's low bits are extended upward by the number of wraps counted since the previous accepted edge. The high time runs from a rising edge to the next falling edge. The low time runs from that falling edge to the rising edge that follows it. When a rising edge completes a period, a sequential divider computes the truncated integer percentage of high time over the whole period.

The percentage output keeps its previous value until a new value is ready. At that point `resultValid` pulses for one clock. If the input stops toggling, the wrap counter passes a limit set by software. The block then reports a flat 100 when the input rests high, or 0 when it rests low. After that it waits for a fresh rising edge before it measures again. Falling edges seen while waiting for a rising edge, whether after reset or after such a fallback, are not used.

Top module: `pwm_duty_meter`

## Requirements
- R1: While reset is held and on the cycle after it, `dutyPct`, `highTicks` and `lowTicks` read 0 and `resultValid` is low.
- R2: `highTicks` equals the number of clock cycles the input stayed high, including spans longer than one timer wrap (2^CNT_W cycles).
- R3: `lowTicks` equals the number of clock cycles the input stayed low between a falling edge and the rising edge that closes the period, including spans longer than one timer wrap.
- R4: After a closing rising edge, `dutyPct` becomes floor(100*high/(high+low)), never exceeds 100, and `resultValid` pulses within 200 cycles.
- R5: After reset, a falling edge that comes before the first rising edge is not used. No result is produced until a rising edge, a falling edge and a second rising edge have been seen.
- R6: `resultValid` is high for exactly one cycle at a time, and `dutyPct` does not change in any cycle in which `resultValid` is low.
- R7: When the fallback fires, `dutyPct` becomes 100 if the input rests high and 0 if it rests low, `resultValid` pulses, and `highTicks`/`lowTicks` keep their values.
- R8: The fallback fires once the wrap count since the last accepted edge exceeds `ovfLimit`. That point lies between ovfLimit*2^CNT_W and (ovfLimit+1)*2^CNT_W cycles after that edge. `ovfLimit` must be below 2^OVF_W-1.
- R9: After the fallback fires, a falling edge is not used, and measuring restarts at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwmIn | input | 1 | Raw asynchronous PWM input |
| ovfLimit | input | OVF_W | Number of timer wraps tolerated without an edge |
| dutyPct | output | 8 | Duty cycle in percent, 0 to 100 |
| highTicks | output | CNT_W+OVF_W | Last measured high time in clock cycles |
| lowTicks | output | CNT_W+OVF_W | Last measured low time in clock cycles |
| resultValid | output | 1 | One-cycle strobe when `dutyPct` is updated |

## Verification
A table of high/low lengths covers low, middle and high duty cycles. It includes single-cycle pulses at either extreme, which separate truncation from rounding and confirm that short pulses survive the synchronizer. One entry has a high phase longer than one timer wrap, which shows that the wrap extension is applied. Directed runs start from reset with the input already high, and also follow a fallback, to confirm that the stray falling edge is discarded. Further runs hold the input high and then low to check the fallback level, the timing window set by the limit, and that the duration outputs stay unchanged.

// File: rtl/pwm_duty_pkg.sv
package pwm_duty_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HIGH,
    ST_LOW
  } meas_state_t;

  // control-to-datapath strobes for one cycle
  typedef struct packed {
    logic stampRise;    // accepted rising edge: new reference
    logic stampFall;    // accepted falling edge: latch high time
    logic closePeriod;  // rising edge that completes a period
    logic timeout;      // no edge for too long
    logic clearOvf;     // restart wrap counting
    logic pinLevel;     // synchronized input level
  } meter_strobe_t;

endpackage

// File: rtl/pwm_duty_ctrl.sv
module pwm_duty_ctrl
  import pwm_duty_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          pinRaw,
  input  logic          ovfExceeded,
  output meter_strobe_t strb
);

  logic [1:0]  syncQ;
  logic        prevLvl;
  logic        curLvl;
  logic        riseEdge;
  logic        fallEdge;
  logic        accepted;
  meas_state_t state;
  meas_state_t nextState;

  // two-stage synchronizer and edge history, no reset needed
  always_ff @(posedge clk) begin
    syncQ   <= {syncQ[0], pinRaw};
    prevLvl <= syncQ[1];
  end

  assign curLvl   = syncQ[1];
  assign riseEdge = curLvl & ~prevLvl;
  assign fallEdge = ~curLvl & prevLvl;

  always_comb begin
    strb          = '0;
    strb.pinLevel = curLvl;
    nextState     = state;
    case (state)
      ST_IDLE: if (riseEdge) begin
        strb.stampRise = 1'b1;
        nextState      = ST_HIGH;
      end
      ST_HIGH: if (fallEdge) begin
        strb.stampFall = 1'b1;
        nextState      = ST_LOW;
      end
      ST_LOW: if (riseEdge) begin
        strb.stampRise   = 1'b1;
        strb.closePeriod = 1'b1;
        nextState        = ST_HIGH;
      end
      default: nextState = ST_IDLE;
    endcase
    accepted = strb.stampRise | strb.stampFall;
    if (!accepted && ovfExceeded) begin
      strb.timeout = 1'b1;
      nextState    = ST_IDLE;
    end
    strb.clearOvf = accepted | strb.timeout;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

endmodule

// File: rtl/pwm_duty_div.sv
module pwm_duty_div #(
  parameter int NUM_W = 31,
  parameter int DEN_W = 25,
  parameter int Q_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cancel,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [Q_W-1:0]   quo
);

  localparam int STEP_W = $clog2(NUM_W);

  logic              busy;
  logic [NUM_W-1:0]  numSh;
  logic [DEN_W-1:0]  denQ;
  logic [DEN_W-1:0]  rem;
  logic [STEP_W-1:0] steps;
  logic [DEN_W:0]    trial;
  logic [DEN_W:0]    diff;
  logic              fits;

  // restoring step: quotient bits shift in where numerator bits leave
  assign trial = {rem, numSh[NUM_W-1]};
  assign diff  = trial - {1'b0, denQ};
  assign fits  = ~diff[DEN_W];
  assign quo   = numSh[Q_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      numSh <= '0;
      denQ  <= '0;
      rem   <= '0;
      steps <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        numSh <= num;
        denQ  <= den;
        rem   <= '0;
        steps <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        rem   <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        numSh <= {numSh[NUM_W-2:0], fits};
        steps <= steps + 1'b1;
        if (steps == STEP_W'(NUM_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pwm_duty_dp.sv
module pwm_duty_dp
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OVF_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  meter_strobe_t          strb,
  input  logic [OVF_W-1:0]       ovfLimit,
  output logic                   ovfExceeded,
  output logic [7:0]             dutyPct,
  output logic [CNT_W+OVF_W-1:0] highDur,
  output logic [CNT_W+OVF_W-1:0] lowDur,
  output logic                   resultValid
);

  localparam int DUR_W = CNT_W + OVF_W;
  localparam int NUM_W = DUR_W + 7;
  localparam int DEN_W = DUR_W + 1;

  logic [CNT_W-1:0] tmr;
  logic [CNT_W-1:0] refT;
  logic [OVF_W-1:0] ovfCnt;
  logic             wrap;
  logic [DUR_W-1:0] elapsed;
  logic [DEN_W-1:0] sumDur;
  logic [NUM_W-1:0] numer;
  logic             divStart;
  logic             divDone;
  logic [7:0]       divQuo;

  assign wrap        = &tmr;
  assign ovfExceeded = ovfCnt > ovfLimit;
  // extended stamp minus the 16-bit reference of the previous edge
  assign elapsed  = {ovfCnt, tmr} - {{OVF_W{1'b0}}, refT};
  assign sumDur   = {1'b0, highDur} + {1'b0, elapsed};
  assign numer    = NUM_W'(highDur) * NUM_W'(100);
  assign divStart = strb.closePeriod && (sumDur != '0);

  pwm_duty_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(8)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (divStart),
    .cancel(strb.timeout),
    .num   (numer),
    .den   (sumDur),
    .done  (divDone),
    .quo   (divQuo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr         <= '0;
      refT        <= '0;
      ovfCnt      <= '0;
      highDur     <= '0;
      lowDur      <= '0;
      dutyPct     <= '0;
      resultValid <= 1'b0;
    end else begin
      tmr <= tmr + 1'b1;
      if (strb.clearOvf)
        ovfCnt <= wrap ? OVF_W'(1) : '0;
      else if (wrap && !(&ovfCnt))
        ovfCnt <= ovfCnt + 1'b1;
      if (strb.stampFall)   highDur <= elapsed;
      if (strb.closePeriod) lowDur  <= elapsed;
      if (strb.stampRise || strb.stampFall) refT <= tmr;
      resultValid <= 1'b0;
      if (strb.timeout) begin
        dutyPct     <= strb.pinLevel ? 8'd100 : 8'd0;
        resultValid <= 1'b1;
      end else if (divDone) begin
        dutyPct     <= divQuo;
        resultValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_duty_meter.sv
module pwm_duty_meter
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OVF_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pwmIn,
  input  logic [OVF_W-1:0]       ovfLimit,
  output logic [7:0]             dutyPct,
  output logic [CNT_W+OVF_W-1:0] highTicks,
  output logic [CNT_W+OVF_W-1:0] lowTicks,
  output logic                   resultValid
);

  localparam int DUR_W = CNT_W + OVF_W;

  meter_strobe_t strb;
  logic          ovfExceeded;

  pwm_duty_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pinRaw     (pwmIn),
    .ovfExceeded(ovfExceeded),
    .strb       (strb)
  );

  pwm_duty_dp #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .ovfLimit   (ovfLimit),
    .ovfExceeded(ovfExceeded),
    .dutyPct    (dutyPct),
    .highDur    (highTicks),
    .lowDur     (lowTicks),
    .resultValid(resultValid)
  );

endmodule

// File: rtl/pwm_duty_meter_chk.sv
module pwm_duty_meter_chk
  import pwm_duty_pkg::*;
#(
  parameter int DUR_W = 24
) (
  input logic             clk,
  input logic             rst,
  input meter_strobe_t    strb,
  input logic [7:0]       dutyPct,
  input logic [DUR_W-1:0] highTicks,
  input logic [DUR_W-1:0] lowTicks,
  input logic             resultValid
);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);  // R6

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !resultValid |-> $stable(dutyPct));  // R6

  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (rst)
    dutyPct <= 8'd100);  // R4

  AST_HIGH_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(highTicks) |-> $past(strb.stampFall));  // R2

  AST_LOW_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(lowTicks) |-> $past(strb.closePeriod));  // R3

  AST_TIMEOUT_KEEPS_DUR: assert property (@(posedge clk) disable iff (rst)
    strb.timeout |=> $stable(highTicks) && $stable(lowTicks));  // R7

endmodule

bind pwm_duty_meter pwm_duty_meter_chk #(.DUR_W(DUR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .strb       (strb),
  .dutyPct    (dutyPct),
  .highTicks  (highTicks),
  .lowTicks   (lowTicks),
  .resultValid(resultValid)
);

// File: tb/pwm_duty_meter_tb.sv
module pwm_duty_meter_tb;

  localparam int CW    = 8;
  localparam int OW    = 4;
  localparam int DW    = CW + OW;
  localparam int LIMIT = 3;
  localparam int NVEC  = 10;
  // high cycles, low cycles
  localparam int VEC [NVEC][2] = '{
    '{10, 30}, '{30, 10}, '{1, 99}, '{99, 1}, '{300, 100},
    '{7, 3},   '{1, 2},   '{50, 50}, '{200, 700}, '{2, 1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwmIn = 1'b0;
  logic [OW-1:0] ovfLimit = OW'(LIMIT);
  logic [7:0]    dutyPct;
  logic [DW-1:0] highTicks;
  logic [DW-1:0] lowTicks;
  logic          resultValid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int validSeen = 0;
  bit finished = 1'b0;

  pwm_duty_meter #(.CNT_W(CW), .OVF_W(OW)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .pwmIn      (pwmIn),
    .ovfLimit   (ovfLimit),
    .dutyPct    (dutyPct),
    .highTicks  (highTicks),
    .lowTicks   (lowTicks),
    .resultValid(resultValid)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (!rst && resultValid) validSeen = validSeen + 1;

  task automatic check(string req, string what, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkRange(string req, string what, int act, int lo, int hi);
    checks = checks + 1;
    if (act < lo || act > hi) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic doReset(bit lvl);
    rst   = 1'b1;
    pwmIn = lvl;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitValid(output int n);
    n = 0;
    while (!resultValid && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // one full period starting with the input low; leaves the input high
  task automatic measure(string req, int hi, int lo);
    int n;
    int expDuty;
    logic [7:0] held;
    expDuty   = (100 * hi) / (hi + lo);
    validSeen = 0;
    pwmIn = 1'b1;
    repeat (hi) @(negedge clk);
    pwmIn = 1'b0;
    repeat (lo) @(negedge clk);
    check("R5", "results before period closes", validSeen, 0);
    pwmIn = 1'b1;
    waitValid(n);
    checkRange("R4", "cycles to result", n, 1, 200);
    check(req, "duty", dutyPct, expDuty);
    check("R2", "high ticks", highTicks, hi);
    check("R3", "low ticks", lowTicks, lo);
    held = dutyPct;
    @(negedge clk);
    check("R6", "valid after one cycle", resultValid, 0);
    check("R6", "duty held", dutyPct, held);
  endtask

  initial begin
    int n;
    logic [DW-1:0] hi0;
    logic [DW-1:0] lo0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "duty in reset", dutyPct, 0);
    check("R1", "high in reset", highTicks, 0);
    check("R1", "low in reset", lowTicks, 0);
    check("R1", "valid in reset", resultValid, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "duty after reset", dutyPct, 0);

    for (int i = 0; i < NVEC; i++) begin
      doReset(1'b0);
      measure("R4", VEC[i][0], VEC[i][1]);
    end

    // input rests high: fallback to 100, window set by the limit
    hi0 = highTicks;
    lo0 = lowTicks;
    waitValid(n);
    check("R7", "duty at high rest", dutyPct, 100);
    check("R7", "high ticks kept", highTicks, hi0);
    check("R7", "low ticks kept", lowTicks, lo0);
    checkRange("R8", "cycles to fallback", n, 700, 1100);

    // fallback then a stray falling edge: must be ignored
    @(negedge clk);
    pwmIn = 1'b0;
    validSeen = 0;
    repeat (20) @(negedge clk);
    check("R9", "no result from stray fall", validSeen, 0);
    measure("R9", 10, 30);

    // input rests low: fallback to 0
    repeat (15) @(negedge clk);
    pwmIn = 1'b0;
    @(negedge clk);
    waitValid(n);
    check("R7", "duty at low rest", dutyPct, 0);
    checkRange("R8", "cycles to low fallback", n, 700, 1100);

    // reset with input high: first fall discarded
    doReset(1'b1);
    repeat (5) @(negedge clk);
    pwmIn = 1'b0;
    repeat (20) @(negedge clk);
    measure("R5", 10, 30);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule